// File: doc/BRIEF.md
# Backdoor Key Security Gate

This block holds the security state of a device whose code store can be locked against outside access. After reset it captures a security configuration byte and a set of stored key bytes from nonvolatile storage, decodes from the low two bits of that byte whether the device is open or locked, and presents the result on a single `secured` output. Until the first configuration load after reset the device is treated as locked with key access disabled.

A locked device can be opened for the rest of the power cycle by issuing a key verification command. Firmware or a serial receiver first loads the candidate key bytes into a small parallel candidate buffer, one byte per write, then pulses `verify_go`. If key access is enabled by the top two bits of the configuration byte, the block walks the stored and candidate keys one byte per cycle and reports a done pulse with a pass or fail result after the last byte. A pass opens the device. A fail keeps it locked and refuses every further attempt until reset. Commands that cannot run are refused at once with an access error.

Top module: `sec_unlock`

## Requirements
- R1: While reset is held and after its release, before any configuration load, `secured` is 1, `busy` is 0 and `vfy_done` is 0.
- R2: After a configuration load, `secured` is 0 when bits [1:0] of the configuration byte equal 2'b10 and 1 for the values 2'b00, 2'b01 and 2'b11.
- R3: Only the first configuration load after reset is captured; later loads change neither the security state nor the stored keys.
- R4: A command taken while key access is off (configuration bits [7:6] not equal to 2'b10), while the device is already open, or before any configuration load is refused: in the cycle after `verify_go` is sampled `vfy_done` and `vfy_acc_err` are 1 and `vfy_pass` is 0, with no comparison run and `secured` unchanged.
- R5: An accepted command raises `busy` in the cycle after `verify_go` is sampled, compares candidate byte i (written with `cand_idx` = i) against stored byte i (bits [8i+7:8i] of `cfg_keys`) for i = 0 to NUM_KEYS-1, one byte per cycle, and pulses `vfy_done` for one cycle NUM_KEYS cycles after `verify_go` is sampled.
- R6: When every byte matches, `vfy_pass` is 1 with `vfy_done`, and `secured` falls to 0 in that same cycle.
- R7: A mismatch at any byte position gives `vfy_pass` 0 with `vfy_done` and keeps `secured` at 1; every later command is then refused as in R4 until reset.
- R8: A reset discards an earlier unlock or lockout; after the next configuration load `secured` again follows bits [1:0] alone and a correct key command is accepted again.
- R9: A candidate write in the same cycle as an accepted `verify_go` is used by the comparison; candidate writes while `busy` is 1 are ignored.
- R10: A `verify_go` pulse while `busy` is 1 is ignored and produces no extra `vfy_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration from nonvolatile storage is valid this cycle |
| cfg_sec | input | 8 | Security configuration byte |
| cfg_keys | input | NUM_KEYS*KEY_W | Stored key bytes, byte i at bits [8i+7:8i] |
| cand_wr | input | 1 | Write one candidate key byte |
| cand_idx | input | IDX_W | Candidate byte position |
| cand_byte | input | KEY_W | Candidate byte value |
| verify_go | input | 1 | Launch a key verification command |
| secured | output | 1 | Device is locked |
| busy | output | 1 | Key comparison in progress |
| vfy_done | output | 1 | One-cycle completion pulse of a command |
| vfy_pass | output | 1 | All key bytes matched (valid with vfy_done) |
| vfy_acc_err | output | 1 | Command refused (valid with vfy_done) |

## Verification
Two functions meet in one cycle when a candidate byte write lands on the same edge that samples `verify_go`; the bench writes the correct byte 0 exactly then, after loading a wrong byte 0 beforehand, and judges the result by a pass. A second collision is a `verify_go` or a stray candidate write while the walk is running: the bench injects both in the middle of a comparison and requires exactly one done pulse at the normal latency with the original result. All sixteen combinations of the access and security fields are swept, and a mismatch is forced at each of the eight byte positions.

// File: rtl/sec_pkg.sv
// Shared encodings for the security gate.
// Assumes an 8-bit security configuration byte with the lock field in
// bits [1:0] and the key-access field in bits [7:6].
package sec_pkg;

    localparam logic [1:0] LOCK_FIELD_OPEN = 2'b10;
    localparam logic [1:0] KEYS_FIELD_ON   = 2'b10;
    localparam logic [7:0] SEC_BYTE_RESET  = 8'hFF;

    typedef enum logic {
        CMP_IDLE = 1'b0,
        CMP_RUN  = 1'b1
    } cmp_state_t;

    // Lock decode: every pattern but one keeps the device locked.
    function automatic logic lock_decode(input logic [7:0] sec_byte);
        return sec_byte[1:0] != LOCK_FIELD_OPEN;
    endfunction

    // Key access is allowed for exactly one pattern of the top field.
    function automatic logic keys_allowed(input logic [7:0] sec_byte);
        return sec_byte[7:6] == KEYS_FIELD_ON;
    endfunction

endpackage

// File: rtl/sec_cfg_hold.sv
// Captures the security byte and stored keys on the first load after
// reset and holds them until the next reset.
// Assumes the load pulse comes from the nonvolatile storage reader.
module sec_cfg_hold #(
    parameter int NUM_KEYS = 8,
    parameter int KEY_W    = 8,
    localparam int KEYS_W  = NUM_KEYS * KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [7:0]        sec_in,
    input  logic [KEYS_W-1:0] keys_in,
    output logic              valid,
    output logic [7:0]        sec_q,
    output logic [KEYS_W-1:0] keys_q
);
    import sec_pkg::*;

    // Single-shot capture; a locked default is held until then.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            sec_q  <= SEC_BYTE_RESET;
            keys_q <= '0;
        end else if (load && !valid) begin
            valid  <= 1'b1;
            sec_q  <= sec_in;
            keys_q <= keys_in;
        end
    end

endmodule

// File: rtl/sec_cand_buf.sv
// Candidate key buffer written one byte per cycle from a parallel port.
// Assumes writes are frozen by the caller while a comparison is running.
module sec_cand_buf #(
    parameter int NUM_KEYS = 8,
    parameter int KEY_W    = 8,
    localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
    localparam int KEYS_W  = NUM_KEYS * KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              freeze,
    input  logic [IDX_W-1:0]  idx,
    input  logic [KEY_W-1:0]  data,
    output logic [KEYS_W-1:0] cand
);

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
        // One byte slot, written when its position is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cand[g*KEY_W +: KEY_W] <= '0;
            end else if (wr && !freeze && (idx == IDX_W'(g))) begin
                cand[g*KEY_W +: KEY_W] <= data;
            end
        end
    end

endmodule

// File: rtl/sec_key_cmp.sv
// Byte-serial comparator: walks NUM_KEYS byte pairs, one per cycle,
// and exposes the final step with the accumulated match.
// Assumes start is only honoured while idle.
module sec_key_cmp #(
    parameter int NUM_KEYS = 8,
    parameter int KEY_W    = 8,
    localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
    localparam int KEYS_W  = NUM_KEYS * KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEYS_W-1:0] stored,
    input  logic [KEYS_W-1:0] cand,
    output logic              busy,
    output logic              step_last,
    output logic              all_match
);
    import sec_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_KEYS - 1);

    cmp_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             run_ok;
    logic [KEY_W-1:0] stored_b;
    logic [KEY_W-1:0] cand_b;
    logic             byte_eq;

    // Select the current byte pair and compare it.
    always_comb begin
        stored_b  = stored[int'(idx)*KEY_W +: KEY_W];
        cand_b    = cand[int'(idx)*KEY_W +: KEY_W];
        byte_eq   = (stored_b == cand_b);
        busy      = (state == CMP_RUN);
        step_last = busy && (idx == LAST_IDX);
        all_match = run_ok && byte_eq;
    end

    // Walk the byte positions and accumulate the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CMP_IDLE;
            idx    <= '0;
            run_ok <= 1'b0;
        end else if (state == CMP_IDLE) begin
            if (start) begin
                state  <= CMP_RUN;
                idx    <= '0;
                run_ok <= 1'b1;
            end
        end else begin
            run_ok <= run_ok && byte_eq;
            if (idx == LAST_IDX) begin
                state <= CMP_IDLE;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sec_ctrl.sv
// Command control: accepts or refuses a verify command, records the
// unlock or lockout for the rest of the reset period, and drives the
// registered result pulse.
// Assumes the comparator's last-step signals are valid only while busy.
module sec_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       cfg_valid,
    input  logic [7:0] sec_q,
    input  logic       cmp_busy,
    input  logic       step_last,
    input  logic       all_match,
    output logic       start,
    output logic       secured,
    output logic       done,
    output logic       pass,
    output logic       acc_err
);
    import sec_pkg::*;

    logic unlocked;
    logic blocked;
    logic take;
    logic accept;
    logic unused_sec_bits;

    assign unused_sec_bits = ^sec_q[5:2];

    // Decide whether a command is taken and whether it may run.
    always_comb begin
        secured = lock_decode(sec_q) && !unlocked;
        accept  = cfg_valid && keys_allowed(sec_q) && secured && !blocked;
        take    = go && !cmp_busy;
        start   = take && accept;
    end

    // Result pulse plus sticky unlock and lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            blocked  <= 1'b0;
            done     <= 1'b0;
            pass     <= 1'b0;
            acc_err  <= 1'b0;
        end else begin
            done    <= 1'b0;
            pass    <= 1'b0;
            acc_err <= 1'b0;
            if (take && !accept) begin
                done    <= 1'b1;
                acc_err <= 1'b1;
            end
            if (step_last) begin
                done <= 1'b1;
                pass <= all_match;
                if (all_match) begin
                    unlocked <= 1'b1;
                end else begin
                    blocked <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sec_unlock.sv
// Top of the security gate: configuration capture, candidate buffer,
// serial key comparator and command control.
// Assumes cfg_load arrives after reset from the nonvolatile reader.
module sec_unlock #(
    parameter int NUM_KEYS = 8,
    parameter int KEY_W    = 8,
    localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
    localparam int KEYS_W  = NUM_KEYS * KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_sec,
    input  logic [KEYS_W-1:0] cfg_keys,
    input  logic              cand_wr,
    input  logic [IDX_W-1:0]  cand_idx,
    input  logic [KEY_W-1:0]  cand_byte,
    input  logic              verify_go,
    output logic              secured,
    output logic              busy,
    output logic              vfy_done,
    output logic              vfy_pass,
    output logic              vfy_acc_err
);

    logic              cfg_valid;
    logic [7:0]        sec_q;
    logic [KEYS_W-1:0] keys_q;
    logic [KEYS_W-1:0] cand;
    logic              cmp_start;
    logic              step_last;
    logic              all_match;

    sec_cfg_hold #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .sec_in  (cfg_sec),
        .keys_in (cfg_keys),
        .valid   (cfg_valid),
        .sec_q   (sec_q),
        .keys_q  (keys_q)
    );

    sec_cand_buf #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) u_cand (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cand_wr),
        .freeze (busy),
        .idx    (cand_idx),
        .data   (cand_byte),
        .cand   (cand)
    );

    sec_key_cmp #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmp_start),
        .stored    (keys_q),
        .cand      (cand),
        .busy      (busy),
        .step_last (step_last),
        .all_match (all_match)
    );

    sec_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (verify_go),
        .cfg_valid (cfg_valid),
        .sec_q     (sec_q),
        .cmp_busy  (busy),
        .step_last (step_last),
        .all_match (all_match),
        .start     (cmp_start),
        .secured   (secured),
        .done      (vfy_done),
        .pass      (vfy_pass),
        .acc_err   (vfy_acc_err)
    );

endmodule

// File: rtl/sec_unlock_chk.sv
// Property checker for the security gate, bound to the top module.
module sec_unlock_chk #(
    parameter int NUM_KEYS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic verify_go,
    input logic secured,
    input logic busy,
    input logic vfy_done,
    input logic vfy_pass,
    input logic vfy_acc_err
);

    int unsigned busy_run;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    a_r1_reset_locked: assert property (@(posedge clk)
        !rst_n |=> secured && !busy && !vfy_done);

    a_r4_refuse_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_acc_err |-> vfy_done && !vfy_pass);

    a_r5_walk_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < NUM_KEYS);

    a_r5_start_from_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(verify_go));

    a_r5_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_done |-> !busy);

    a_r6_pass_opens: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_done && vfy_pass |-> !secured);

    a_r7_fail_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_done && !vfy_pass && !vfy_acc_err |-> secured);

    a_r8_open_until_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !secured |=> !secured);

endmodule

bind sec_unlock sec_unlock_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .verify_go   (verify_go),
    .secured     (secured),
    .busy        (busy),
    .vfy_done    (vfy_done),
    .vfy_pass    (vfy_pass),
    .vfy_acc_err (vfy_acc_err)
);

// File: tb/sec_unlock_tb.sv
module sec_unlock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NK = 8;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [7:0]    cfg_sec = 8'h00;
    logic [NK*KW-1:0] cfg_keys = '0;
    logic          cand_wr = 1'b0;
    logic [2:0]    cand_idx = '0;
    logic [KW-1:0] cand_byte = '0;
    logic          verify_go = 1'b0;
    logic          secured, busy, vfy_done, vfy_pass, vfy_acc_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_unlock u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sec(cfg_sec),
        .cfg_keys(cfg_keys), .cand_wr(cand_wr), .cand_idx(cand_idx),
        .cand_byte(cand_byte), .verify_go(verify_go), .secured(secured),
        .busy(busy), .vfy_done(vfy_done), .vfy_pass(vfy_pass),
        .vfy_acc_err(vfy_acc_err)
    );

    function automatic logic [7:0] key_of(input int i, input int seed);
        return 8'((8'h5A ^ (i * 37) ^ seed) & 8'hFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic load_cfg(input logic [7:0] sb, input int seed);
        @(negedge clk);
        cfg_sec = sb;
        for (int i = 0; i < NK; i++) cfg_keys[i*KW +: KW] = key_of(i, seed);
        cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic write_cand(input int idx, input logic [7:0] b);
        @(negedge clk);
        cand_wr = 1'b1; cand_idx = 3'(idx); cand_byte = b;
        @(negedge clk); cand_wr = 1'b0;
    endtask

    task automatic write_all(input int seed, input int bad_pos);
        for (int i = 0; i < NK; i++)
            write_cand(i, (i == bad_pos) ? ~key_of(i, seed) : key_of(i, seed));
    endtask

    // Pulse go, then count negedges until done; lat 0 means refused at once.
    task automatic run_verify(output int lat, output logic p, output logic e);
        @(negedge clk); verify_go = 1'b1;
        @(negedge clk); verify_go = 1'b0;
        lat = 0;
        while (!vfy_done && lat < 12) begin @(negedge clk); lat++; end
        p = vfy_pass; e = vfy_acc_err;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic p, e;
        int ndone;

        // R1 reset state, before any load
        @(negedge clk);
        chk("R1 secured in reset", secured, 1);
        chk("R1 done in reset", vfy_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 secured", secured, 1);
        chk("R1 busy", busy, 0);
        // R4 command before load refused
        run_verify(lat, p, e);
        chk("R4 unloaded latency", lat, 0);
        chk("R4 unloaded acc_err", e, 1);

        // Sweep both two-bit fields: R2 R4 R5 R6 R8
        for (int hi = 0; hi < 4; hi++) begin
            for (int lo = 0; lo < 4; lo++) begin
                logic [7:0] sb;
                logic base_lock, keys_on, ok;
                sb = {2'(hi), 4'b0110, 2'(lo)};
                base_lock = (lo != 2);
                keys_on = (hi == 2);
                ok = base_lock && keys_on;
                do_reset();
                load_cfg(sb, hi * 4 + lo);
                chk("R2 decode", secured, base_lock);
                write_all(hi * 4 + lo, -1);
                run_verify(lat, p, e);
                if (ok) begin
                    chk("R5 latency", lat, NK);
                    chk("R6 pass", p, 1);
                    chk("R6 opened", secured, 0);
                end else begin
                    chk("R4 refused latency", lat, 0);
                    chk("R4 refused err", e, 1);
                    chk("R4 state kept", secured, base_lock);
                end
                do_reset();
                load_cfg(sb, hi * 4 + lo);
                chk("R8 back to decode", secured, base_lock);
            end
        end

        // R3 second load ignored
        do_reset();
        load_cfg(8'hBF, 3);
        load_cfg(8'h82, 9);
        chk("R3 second load ignored", secured, 1);
        write_all(3, -1);
        run_verify(lat, p, e);
        chk("R3 first keys kept", p, 1);

        // R7 mismatch at each position, lockout, then R8 recovery
        for (int pos = 0; pos < NK; pos++) begin
            do_reset();
            load_cfg(8'hBC, 20 + pos);
            write_all(20 + pos, pos);
            run_verify(lat, p, e);
            chk("R7 fail latency", lat, NK);
            chk("R7 fail pass", p, 0);
            chk("R7 fail err", e, 0);
            chk("R7 still locked", secured, 1);
            write_all(20 + pos, -1);
            run_verify(lat, p, e);
            chk("R7 lockout refused", e, 1);
            chk("R7 lockout locked", secured, 1);
            do_reset();
            load_cfg(8'hBC, 20 + pos);
            write_all(20 + pos, -1);
            run_verify(lat, p, e);
            chk("R8 retry after reset", p, 1);
        end

        // R9 write with go, stray write while busy; R10 go while busy
        do_reset();
        load_cfg(8'hBC, 40);
        write_all(40, 0);
        @(negedge clk);
        verify_go = 1'b1; cand_wr = 1'b1; cand_idx = 3'd0; cand_byte = key_of(0, 40);
        @(negedge clk);
        verify_go = 1'b0; cand_wr = 1'b0;
        chk("R9 busy after go", busy, 1);
        ndone = 0;
        for (int c = 1; c <= NK + 3; c++) begin
            if (c == 3) begin cand_wr = 1'b1; cand_idx = 3'd5; cand_byte = ~key_of(5, 40); end
            if (c == 4) begin cand_wr = 1'b0; verify_go = 1'b1; end
            if (c == 5) verify_go = 1'b0;
            @(negedge clk);
            if (vfy_done) begin
                ndone++;
                chk("R10 done at walk end", c, NK);
                chk("R9 pass", vfy_pass, 1);
            end
        end
        chk("R10 single done", ndone, 1);
        chk("R9 opened", secured, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule